// File: doc/BRIEF.md
# Per-Lane Bit Error Rate Counter

This block measures the receive bit error rate of several serial lanes. Every lane has a seconds countdown timer and an error counter. Both sit in a 16-bit register space that a management bus adapter drives through a plain read and write strobe. When software writes a lane's timer, a new measurement window starts and that lane's error count is cleared. The receivers produce one pulse for each detected error, and the counter accumulates these pulses while the window is still open.

A countdown step comes either from an external single-cycle seconds tick or from an internal prescaler whose reload value is a parameter. Software can read the timer at any point in the window. A partially elapsed window can therefore be scaled to a rate: divide the count by the seconds used so far. Once the timer reaches zero it stays there, and the count is frozen until the next timer write.

Top module: `lane_ber_meter`

## Requirements
- R1: After a synchronous active-low reset, every lane timer, every error count and the read data output are zero.
- R2: Lane n has its timer register at address 0xC0D4 + n*0x80 and its error count register at the following address (0xC0D5 + n*0x80). The count register is read-only: writes to it are ignored. Any other address reads as zero, and a write to it changes nothing.
- R3: Writing a lane's timer register loads the written value into that timer and clears that lane's error count in the same clock edge. The write takes priority over a seconds tick in that cycle.
- R4: On each seconds tick, every timer that is not zero decreases by one. A timer at zero stays at zero.
- R5: An error pulse raises the lane's count by one, but only while that lane's timer is not zero. While the timer is zero, the count does not change.
- R6: The error count is 16 bits wide and stops at 0xFFFF instead of wrapping.
- R7: If an error pulse and a write to the same lane's timer occur in the same cycle, the count is cleared and the pulse is not counted.
- R8: Lanes are independent: pulses and writes for one lane never change another lane's timer or count.
- R9: A read strobe registers the addressed value, which appears on the read data output one clock later and stays until the next read strobe. A running timer can be read mid-window.
- R10: With the internal prescaler selected, a countdown step occurs once every PRESCALE clock cycles, and the external tick input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick_i | input | 1 | External one-cycle seconds tick (used when the external source is selected) |
| err_pulse_i | input | NUM_LANES | One pulse per detected error, one bit per lane |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 16 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Registered read data, valid the cycle after a read strobe |

## Verification
Every piece of internal state in this block can be seen directly through a register read. A wrong timer or count therefore appears on `reg_rdata_o` one clock after the next read strobe aimed at that lane. The bench keeps a model of every timer and count and compares after each write, tick burst and pulse burst, so a lost clear, a wrap instead of a saturate, or a count taken while the window is closed shows up at the first read that follows it. A decode error moves a value to another lane's address or makes an unmapped address return data. Reads of neighbouring lanes and of an unmapped address expose that within the same test step.

// File: rtl/ber_pkg.sv
// Package: shared register word type and the lane register address rule.
// Assumes a 16-bit register address and data space.
package ber_pkg;

    localparam int REG_W = 16;

    typedef logic [REG_W-1:0] reg_word_t;

    // Address of a lane's timer (is_cnt=0) or count (is_cnt=1) register
    function automatic reg_word_t lane_reg_addr(input reg_word_t base,
                                                input reg_word_t ofs,
                                                input reg_word_t stride,
                                                input int        lane,
                                                input bit        is_cnt);
        reg_word_t a;
        a = base + ofs + reg_word_t'(lane) * stride;
        return is_cnt ? a + reg_word_t'(1) : a;
    endfunction

endpackage

// File: rtl/ber_tick_gen.sv
// Module: ber_tick_gen
// Produces the one-cycle seconds step used by every lane timer. When
// USE_EXT_TICK is 1 the external tick passes straight through. Otherwise an
// internal counter fires once every PRESCALE cycles and the external tick is
// ignored. Assumes PRESCALE >= 1.
module ber_tick_gen #(
    parameter bit USE_EXT_TICK = 1'b1,
    parameter int PRESCALE     = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_tick_i,
    output logic tick_o
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pre_q;
    logic          pre_tick;

    // Prescaler terminal count
    assign pre_tick = (pre_q == LAST);

    // Free-running prescaler that wraps at PRESCALE-1
    always_ff @(posedge clk) begin
        if (!rst_n)        pre_q <= '0;
        else if (pre_tick) pre_q <= '0;
        else               pre_q <= pre_q + PW'(1);
    end

    // Source selection fixed by parameter
    assign tick_o = USE_EXT_TICK ? ext_tick_i : pre_tick;

    generate
        if (!USE_EXT_TICK && PRESCALE > 1) begin : g_pre_chk
            // R10: internal steps are never back to back
            assert_tick_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o)
                else $error("prescaled tick fired on consecutive cycles");
        end
    endgenerate
endmodule

// File: rtl/ber_addr_decode.sv
// Module: ber_addr_decode
// Decodes a register address into one-hot timer and count hit vectors,
// one pair per lane. Assumes the lane address windows do not overlap.
module ber_addr_decode
    import ber_pkg::*;
#(
    parameter int        NUM_LANES   = 4,
    parameter reg_word_t BANK_BASE   = 16'hC080,
    parameter reg_word_t TMR_OFS     = 16'h0054,
    parameter reg_word_t LANE_STRIDE = 16'h0080
) (
    input  reg_word_t            addr_i,
    output logic [NUM_LANES-1:0] tmr_hit_o,
    output logic [NUM_LANES-1:0] cnt_hit_o
);
    generate
        for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
            localparam reg_word_t TMR_A = lane_reg_addr(BANK_BASE, TMR_OFS, LANE_STRIDE, i, 1'b0);
            localparam reg_word_t CNT_A = lane_reg_addr(BANK_BASE, TMR_OFS, LANE_STRIDE, i, 1'b1);
            // Per-lane address compare
            assign tmr_hit_o[i] = (addr_i == TMR_A);
            assign cnt_hit_o[i] = (addr_i == CNT_A);
        end
    endgenerate

    // R2: at most one register selected for any address
    always_comb begin
        assert_one_hit_R2: assert ($onehot0({tmr_hit_o, cnt_hit_o}))
            else $error("address decodes to several registers");
    end
endmodule

// File: rtl/ber_lane.sv
// Module: ber_lane
// One lane's measurement window: a seconds countdown timer plus a saturating
// error counter. A load restarts the window and clears the count. It wins
// over a tick and over an error pulse in the same cycle. Errors are counted
// only while the timer is non-zero.
module ber_lane #(
    parameter int TMR_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             err_i,
    input  logic             load_i,
    input  logic [TMR_W-1:0] load_val_i,
    output logic [TMR_W-1:0] timer_o,
    output logic [CNT_W-1:0] count_o
);
    logic [TMR_W-1:0] timer_q;
    logic [CNT_W-1:0] count_q;
    logic             open_w;
    logic             full_w;

    // Window open while time remains; counter full at all-ones
    assign open_w = (timer_q != '0);
    assign full_w = (count_q == '1);

    // Countdown timer: load wins, otherwise step down on tick until zero
    always_ff @(posedge clk) begin
        if (!rst_n)                timer_q <= '0;
        else if (load_i)           timer_q <= load_val_i;
        else if (tick_i && open_w) timer_q <= timer_q - TMR_W'(1);
    end

    // Error counter: clear on load, count while open, stop at full
    always_ff @(posedge clk) begin
        if (!rst_n)                           count_q <= '0;
        else if (load_i)                      count_q <= '0;
        else if (err_i && open_w && !full_w)  count_q <= count_q + CNT_W'(1);
    end

    assign timer_o = timer_q;
    assign count_o = count_q;

    // R3: a load leaves the count cleared and the timer at the loaded value
    assert_load_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_q == '0) && (timer_q == $past(load_val_i)))
        else $error("load did not restart the window");
    // R4: a tick steps an open timer down by exactly one
    assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && timer_q != '0) |=> (timer_q == $past(timer_q) - TMR_W'(1)))
        else $error("timer did not step down by one");
    // R4: an expired timer stays at zero
    assert_hold_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_q == '0 && !load_i) |=> (timer_q == '0))
        else $error("expired timer moved");
    // R5: the count is frozen while the window is closed
    assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_q == '0 && !load_i) |=> $stable(count_q))
        else $error("count moved with the window closed");
    // R6: a full counter never wraps
    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '1 && !load_i) |=> (count_q == '1))
        else $error("error counter wrapped");
endmodule

// File: rtl/lane_ber_meter.sv
// Module: lane_ber_meter (top)
// Per-lane bit error rate meter with a 16-bit register interface. Each lane
// has a seconds countdown timer and an error count at fixed addresses. The
// read data is registered: a value appears one cycle after the read strobe.
// Assumes TMR_W and CNT_W are at most 16 and that the strobes come from an
// external management bus adapter.
module lane_ber_meter
    import ber_pkg::*;
#(
    parameter int        NUM_LANES    = 4,
    parameter int        TMR_W        = 16,
    parameter int        CNT_W        = 16,
    parameter bit        USE_EXT_TICK = 1'b1,
    parameter int        PRESCALE     = 100_000_000,
    parameter reg_word_t BANK_BASE    = 16'hC080,
    parameter reg_word_t TMR_OFS      = 16'h0054,
    parameter reg_word_t LANE_STRIDE  = 16'h0080
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sec_tick_i,
    input  logic [NUM_LANES-1:0] err_pulse_i,
    input  logic                 reg_wr_i,
    input  logic                 reg_rd_i,
    input  logic [REG_W-1:0]     reg_addr_i,
    input  logic [REG_W-1:0]     reg_wdata_i,
    output logic [REG_W-1:0]     reg_rdata_o
);
    logic                 tick_w;
    logic [NUM_LANES-1:0] tmr_hit;
    logic [NUM_LANES-1:0] cnt_hit;
    logic [TMR_W-1:0]     timer_w [NUM_LANES];
    logic [CNT_W-1:0]     count_w [NUM_LANES];
    reg_word_t            rd_mux;
    reg_word_t            rdata_q;

    ber_tick_gen #(
        .USE_EXT_TICK (USE_EXT_TICK),
        .PRESCALE     (PRESCALE)
    ) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_tick_i (sec_tick_i),
        .tick_o     (tick_w)
    );

    ber_addr_decode #(
        .NUM_LANES   (NUM_LANES),
        .BANK_BASE   (BANK_BASE),
        .TMR_OFS     (TMR_OFS),
        .LANE_STRIDE (LANE_STRIDE)
    ) u_dec (
        .addr_i    (reg_addr_i),
        .tmr_hit_o (tmr_hit),
        .cnt_hit_o (cnt_hit)
    );

    generate
        for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
            ber_lane #(
                .TMR_W (TMR_W),
                .CNT_W (CNT_W)
            ) u_lane (
                .clk        (clk),
                .rst_n      (rst_n),
                .tick_i     (tick_w),
                .err_i      (err_pulse_i[i]),
                .load_i     (reg_wr_i && tmr_hit[i]),
                .load_val_i (reg_wdata_i[TMR_W-1:0]),
                .timer_o    (timer_w[i]),
                .count_o    (count_w[i])
            );
        end
    endgenerate

    // Read selection: OR of the one addressed register, zero if none
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (tmr_hit[i]) rd_mux = rd_mux | reg_word_t'(timer_w[i]);
            if (cnt_hit[i]) rd_mux = rd_mux | reg_word_t'(count_w[i]);
        end
    end

    // Read data register, updated only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata_q <= '0;
        else if (reg_rd_i) rdata_q <= rd_mux;
    end

    assign reg_rdata_o = rdata_q;

    // R2: a read of an unmapped address returns zero
    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && tmr_hit == '0 && cnt_hit == '0) |=> (reg_rdata_o == '0))
        else $error("unmapped read returned data");
    // R9: read data holds between read strobes
    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_i |=> $stable(reg_rdata_o))
        else $error("read data changed without a read strobe");
endmodule

// File: tb/lane_ber_meter_tb.sv
// Scoreboard bench: driver tasks update a register model and push expected
// read values; a monitor pops and compares them as read data appears.
module lane_ber_meter_tb;
    localparam int NL = 4;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } rd_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic [NL-1:0] err = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [15:0] addr = '0, wdata = '0;
    logic [15:0] rdata;
    logic        wr2 = 1'b0, rd2 = 1'b0;
    logic [15:0] addr2 = '0, wdata2 = '0;
    logic [15:0] rdata2;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    rd_item_t    sb_q[$];
    logic [15:0] m_tmr [NL];
    logic [15:0] m_cnt [NL];

    always #5 clk = ~clk;

    lane_ber_meter u_dut (
        .clk(clk), .rst_n(rst_n), .sec_tick_i(sec_tick), .err_pulse_i(err),
        .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata)
    );

    lane_ber_meter #(.USE_EXT_TICK(1'b0), .PRESCALE(8)) u_pre (
        .clk(clk), .rst_n(rst_n), .sec_tick_i(sec_tick), .err_pulse_i('0),
        .reg_wr_i(wr2), .reg_rd_i(rd2), .reg_addr_i(addr2), .reg_wdata_i(wdata2),
        .reg_rdata_o(rdata2)
    );

    function automatic logic [15:0] tmr_a(input int l);
        return 16'hC0D4 + 16'(l) * 16'h0080;
    endfunction

    function automatic logic [15:0] cnt_a(input int l);
        return 16'hC0D5 + 16'(l) * 16'h0080;
    endfunction

    // Expected read value from the model (R2)
    function automatic logic [15:0] model_rd(input logic [15:0] a);
        for (int l = 0; l < NL; l++) begin
            if (a == tmr_a(l)) return m_tmr[l];
            if (a == cnt_a(l)) return m_cnt[l];
        end
        return 16'h0000;
    endfunction

    task automatic model_load(input logic [15:0] a, input logic [15:0] d);
        for (int l = 0; l < NL; l++)
            if (a == tmr_a(l)) begin m_tmr[l] = d; m_cnt[l] = 16'h0; end
    endtask

    task automatic wr_reg(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
        model_load(a, d);
    endtask

    // Write and an error pulse on the same lane in one cycle (R7)
    task automatic wr_with_err(input int l, input logic [15:0] d);
        @(negedge clk); wr = 1'b1; addr = tmr_a(l); wdata = d; err[l] = 1'b1;
        @(negedge clk); wr = 1'b0; err[l] = 1'b0;
        model_load(tmr_a(l), d);
    endtask

    // Write and a tick in one cycle: write wins (R3)
    task automatic wr_with_tick(input int l, input logic [15:0] d);
        @(negedge clk); wr = 1'b1; addr = tmr_a(l); wdata = d; sec_tick = 1'b1;
        @(negedge clk); wr = 1'b0; sec_tick = 1'b0;
        for (int k = 0; k < NL; k++)
            if (k != l && m_tmr[k] != 0) m_tmr[k] = m_tmr[k] - 16'd1;
        model_load(tmr_a(l), d);
    endtask

    task automatic tick_n(input int n);
        @(negedge clk); sec_tick = 1'b1;
        repeat (n) @(negedge clk);
        sec_tick = 1'b0;
        for (int k = 0; k < n; k++)
            for (int l = 0; l < NL; l++)
                if (m_tmr[l] != 0) m_tmr[l] = m_tmr[l] - 16'd1;
    endtask

    task automatic err_n(input int l, input int n);
        @(negedge clk); err[l] = 1'b1;
        repeat (n) @(negedge clk);
        err[l] = 1'b0;
        for (int k = 0; k < n; k++)
            if (m_tmr[l] != 0 && m_cnt[l] != 16'hFFFF) m_cnt[l] = m_cnt[l] + 16'd1;
    endtask

    // Driver: issue a read and push the expected value
    task automatic rd_reg(input logic [15:0] a, input string tag);
        rd_item_t it;
        it.exp = model_rd(a);
        it.tag = tag;
        @(negedge clk); rd = 1'b1; addr = a;
        sb_q.push_back(it);
        @(negedge clk); rd = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: a read strobe seen at an edge yields data by the next negedge
    initial begin
        forever begin
            @(posedge clk);
            if (rd) begin
                @(negedge clk);
                if (sb_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R9: unexpected read data %h, expected none", rdata);
                end else begin
                    rd_item_t it;
                    it = sb_q.pop_front();
                    n_cmp++;
                    if (rdata !== it.exp) begin
                        n_bad++;
                        $display("FAIL %s: got %h expected %h", it.tag, rdata, it.exp);
                    end
                end
            end
        end
    end

    task automatic check_range(input logic [15:0] v, input int lo, input int hi, input string tag);
        n_cmp++;
        if (int'(v) < lo || int'(v) > hi) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d..%0d", tag, v, lo, hi);
        end
    endtask

    task automatic pre_wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); wr2 = 1'b1; addr2 = a; wdata2 = d;
        @(negedge clk); wr2 = 1'b0;
    endtask

    task automatic pre_rd(input logic [15:0] a, output logic [15:0] v);
        @(negedge clk); rd2 = 1'b1; addr2 = a;
        @(negedge clk); rd2 = 1'b0; v = rdata2;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        for (int l = 0; l < NL; l++) begin m_tmr[l] = '0; m_cnt[l] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        n_cmp++;
        if (rdata !== 16'h0) begin
            n_bad++; $display("FAIL R1: rdata %h expected 0000", rdata);
        end
        rd_reg(tmr_a(0), "R1 lane0 timer");
        rd_reg(cnt_a(3), "R1 lane3 count");

        // R3/R9: load a window and read it back
        wr_reg(tmr_a(0), 16'd10);
        rd_reg(tmr_a(0), "R3 lane0 timer load");
        rd_reg(cnt_a(0), "R3 lane0 count clear");

        // R5/R8: errors on lane 0 only
        err_n(0, 5);
        rd_reg(cnt_a(0), "R5 lane0 count");
        rd_reg(cnt_a(1), "R8 lane1 untouched");

        // R4/R9: partial window readable
        tick_n(3);
        rd_reg(tmr_a(0), "R9 partial window timer");

        // R2: count register is read-only; unmapped address reads zero
        wr_reg(cnt_a(0), 16'h1234);
        rd_reg(cnt_a(0), "R2 count write ignored");
        wr_reg(16'hC0D6, 16'h5555);
        rd_reg(16'hC0D6, "R2 unmapped reads zero");
        rd_reg(tmr_a(0), "R2 unmapped write ignored");

        // R4/R5: run out the window, then errors are not counted
        tick_n(10);
        rd_reg(tmr_a(0), "R4 timer holds at zero");
        err_n(0, 4);
        rd_reg(cnt_a(0), "R5 count frozen at zero timer");

        // R7: write and error together
        wr_reg(tmr_a(0), 16'd20);
        err_n(0, 2);
        wr_with_err(0, 16'd20);
        rd_reg(cnt_a(0), "R7 clear wins over pulse");
        err_n(0, 1);
        rd_reg(cnt_a(0), "R7 next pulse counted");

        // R3: write wins over tick
        wr_with_tick(0, 16'd9);
        rd_reg(tmr_a(0), "R3 write beats tick");

        // R2/R8: highest lane address
        wr_reg(tmr_a(3), 16'd100);
        err_n(3, 2);
        rd_reg(cnt_a(3), "R2 lane3 count address");
        rd_reg(tmr_a(3), "R2 lane3 timer address");
        rd_reg(cnt_a(2), "R8 lane2 untouched");

        // R6: saturation
        wr_reg(tmr_a(1), 16'hFFFF);
        err_n(1, 65540);
        rd_reg(cnt_a(1), "R6 count saturates");
        rd_reg(cnt_a(0), "R8 lane0 after lane1 burst");

        // R10: internal prescaler ignores the external tick
        pre_wr(tmr_a(2), 16'd50);
        tick_n(20);
        pre_rd(tmr_a(2), v);
        check_range(v, 47, 48, "R10 prescaled countdown");
        pre_wr(tmr_a(2), 16'd3);
        repeat (40) @(negedge clk);
        pre_rd(tmr_a(2), v);
        check_range(v, 0, 0, "R10 prescaled expiry");
        rd_reg(tmr_a(3), "R4 main timer after ticks");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule